// File: doc/BRIEF.md
# Scan Test Access Pin Multiplexer

This block decides, for a handful of chip pins, whether they serve their normal function or carry internal scan test traffic. Scan test is requested either by a dedicated scan-mode package pin or by a reserved instruction loaded through a small JTAG TAP controller built into the block. A static two-bit configuration picks where scan traffic travels. It can use the JTAG pins: scan clock on TCK, first chain in on TDI and out on TDO. It can instead use borrowed UART and SPI pins: scan clock on the SPI clock pad, first chain in on UART receive and out on UART transmit. The remaining parallel chains always use a vector of general-purpose pads.

The scan-mode request is brought into the core clock domain through a two-stage synchronizer. The effective mode register only changes when the shift-enable pin has been low for three consecutive core clock samples, so a chain never sees the mode flip while it shifts. The shift-enable and scan-clock outputs are shared by every chain. While the block is out of scan mode, every borrowed pad passes its functional signal untouched and TDO carries ordinary TAP data.

Top module: `scan_pin_router`

## Requirements
- R1: While rst_n and trst_n are low, scan_mode, scan_shift_en, scan_clk and every scan_si bit are 0 and the borrowed pads pass their functional signals.
- R2: With scan_cfg equal to 0 (or 3), scan_mode stays 0 whatever scan_mode_pin and the instruction register do.
- R3: With scan_cfg equal to 1 or 2 and scan_en_pin low, scan_mode rises on the third rising clk edge after scan_mode_pin goes high, and falls on the third edge after the request goes away.
- R4: Completing an Update-IR with instruction 4'b1000 (4-bit register, shifted LSB first) sets a sticky request flag that enters scan mode like the pin does.
- R5: The request flag is cleared by trst_n low, by entering Test-Logic-Reset, or by an Update-IR of any other opcode.
- R6: scan_mode changes only on a clk edge at which scan_en_pin was sampled low at that edge and at the two previous edges.
- R7: scan_shift_en equals scan_en_pin AND scan_mode; outside scan mode scan_clk and all scan_si are 0.
- R8: With scan_cfg equal to 1 in scan mode, scan_si[0] follows tdi, tdo follows scan_so[0] and scan_clk follows tck, so a bit shifted in reappears on tdo after as many scan clocks as the chain is long.
- R9: With scan_cfg equal to 2 in scan mode, scan_si[0] follows uart_rx_pad, uart_tx_pad follows scan_so[0], scan_clk follows spi_sck_pad, uart_rx_func is held 1 and spi_sck_func is held 0.
- R10: In scan mode chain k (k at least 1) takes scan_si[k] from gp_pad_in[k-1] and drives gp_pad_out[k-1] from scan_so[k]; gp_func_in is held 0.
- R11: Outside scan mode uart_tx_pad, uart_rx_func, spi_sck_func, gp_pad_out and gp_func_in pass their functional counterparts, and tdo carries TAP data: the IR capture value shifts out as 1,0,0,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock used to synchronize the scan-mode request |
| rst_n | input | 1 | Active-low asynchronous core reset |
| scan_cfg | input | 2 | Static pin-sharing scheme: 0 none, 1 JTAG pins, 2 UART/SPI pins |
| scan_mode_pin | input | 1 | Dedicated scan-mode request pad |
| scan_en_pin | input | 1 | Shift-enable pad from the tester |
| tck | input | 1 | JTAG clock |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| trst_n | input | 1 | Active-low JTAG reset |
| tdo | output | 1 | JTAG serial data out or chain 0 scan-out |
| uart_rx_pad | input | 1 | UART receive pad |
| uart_rx_func | output | 1 | UART receive toward the core |
| uart_tx_func | input | 1 | UART transmit from the core |
| uart_tx_pad | output | 1 | UART transmit pad |
| spi_sck_pad | input | 1 | SPI clock pad |
| spi_sck_func | output | 1 | SPI clock toward the core |
| gp_pad_in | input | N_CHAINS-1 | General-purpose input pads |
| gp_func_in | output | N_CHAINS-1 | General-purpose inputs toward the core |
| gp_func_out | input | N_CHAINS-1 | General-purpose outputs from the core |
| gp_pad_out | output | N_CHAINS-1 | General-purpose output pads |
| scan_mode | output | 1 | Effective scan mode to all chains |
| scan_shift_en | output | 1 | Shared shift enable |
| scan_clk | output | 1 | Shared scan clock |
| scan_si | output | N_CHAINS | Scan-in of each chain |
| scan_so | input | N_CHAINS | Scan-out of each chain |

## Verification
Pad routing is combinational, so every pad and scan output is due in the same cycle as the stimulus. The bench drives inputs on the falling clk edge and compares all outputs one nanosecond after each rising edge. The mode request is due on the third rising clk edge after the pin or flag changes, provided shift enable was low on that edge and the two before. The behavioural model carries a three-deep history of request and shift-enable samples to land on that same edge. The instruction flag is due on the TCK rising edge that leaves Update-IR or enters Test-Logic-Reset, which the bench's TAP tasks mark in its model. A chain bit is due on the output pad after exactly chain-length scan clocks, and the shift tasks check it right after each rising scan clock.

// File: rtl/scan_pin_router.sv
module scan_pin_router #(
  parameter int N_CHAINS = 3,
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] SCAN_OP = 'd8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          scan_cfg,
  input  logic                scan_mode_pin,
  input  logic                scan_en_pin,
  input  logic                tck,
  input  logic                tms,
  input  logic                tdi,
  input  logic                trst_n,
  output logic                tdo,
  input  logic                uart_rx_pad,
  output logic                uart_rx_func,
  input  logic                uart_tx_func,
  output logic                uart_tx_pad,
  input  logic                spi_sck_pad,
  output logic                spi_sck_func,
  input  logic [N_CHAINS-2:0] gp_pad_in,
  output logic [N_CHAINS-2:0] gp_func_in,
  input  logic [N_CHAINS-2:0] gp_func_out,
  output logic [N_CHAINS-2:0] gp_pad_out,
  output logic                scan_mode,
  output logic                scan_shift_en,
  output logic                scan_clk,
  output logic [N_CHAINS-1:0] scan_si,
  input  logic [N_CHAINS-1:0] scan_so
);

  localparam int GP_W = N_CHAINS - 1;
  localparam logic [IR_W-1:0] CAP_VAL = IR_W'(1);

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t            st, nxt;
  logic [IR_W-1:0] ir_sr;
  logic            byp;
  logic            tdo_q;
  logic            scan_instr_flag;

  always_comb begin
    case (st)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      UPD_IR:  nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st              <= TLR;
      ir_sr           <= '0;
      byp             <= 1'b0;
      scan_instr_flag <= 1'b0;
    end else begin
      st <= nxt;
      case (st)
        CAP_IR:  ir_sr <= CAP_VAL;
        SH_IR:   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        CAP_DR:  byp <= 1'b0;
        SH_DR:   byp <= tdi;
        UPD_IR:  scan_instr_flag <= (ir_sr == SCAN_OP);
        default: ;
      endcase
      if (nxt == TLR) scan_instr_flag <= 1'b0;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)         tdo_q <= 1'b0;
    else if (st == SH_IR) tdo_q <= ir_sr[0];
    else if (st == SH_DR) tdo_q <= byp;
    else                  tdo_q <= 1'b0;
  end

  logic cfg_scan, req_raw;
  logic req_s1, req_s2, se_s1, se_s2, mode_q;

  assign cfg_scan = (scan_cfg == 2'd1) || (scan_cfg == 2'd2);
  assign req_raw  = (scan_mode_pin | scan_instr_flag) & cfg_scan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      se_s1  <= 1'b0;
      se_s2  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      req_s1 <= req_raw;
      req_s2 <= req_s1;
      se_s1  <= scan_en_pin;
      se_s2  <= se_s1;
      if (!(scan_en_pin | se_s1 | se_s2)) mode_q <= req_s2;
    end
  end

  logic on_jtag, on_uart;
  assign on_jtag = mode_q & (scan_cfg == 2'd1);
  assign on_uart = mode_q & (scan_cfg == 2'd2);

  assign scan_mode     = mode_q;
  assign scan_shift_en = mode_q & scan_en_pin;
  assign scan_clk      = on_jtag ? tck : (on_uart ? spi_sck_pad : 1'b0);
  assign scan_si[0]    = on_jtag ? tdi : (on_uart ? uart_rx_pad : 1'b0);

  assign tdo          = on_jtag ? scan_so[0] : tdo_q;
  assign uart_tx_pad  = on_uart ? scan_so[0] : uart_tx_func;
  assign uart_rx_func = on_uart ? 1'b1 : uart_rx_pad;
  assign spi_sck_func = on_uart ? 1'b0 : spi_sck_pad;

  for (genvar g = 0; g < GP_W; g++) begin : g_gp
    assign scan_si[g+1]  = mode_q ? gp_pad_in[g] : 1'b0;
    assign gp_pad_out[g] = mode_q ? scan_so[g+1] : gp_func_out[g];
    assign gp_func_in[g] = mode_q ? 1'b0 : gp_pad_in[g];
  end

endmodule

// File: rtl/scan_pin_router_chk.sv
module scan_pin_router_chk #(
  parameter int N_CHAINS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          scan_cfg,
  input logic                scan_en_pin,
  input logic                tck,
  input logic                tdi,
  input logic                trst_n,
  input logic                tdo,
  input logic                uart_rx_pad,
  input logic                uart_rx_func,
  input logic                uart_tx_func,
  input logic                uart_tx_pad,
  input logic                spi_sck_pad,
  input logic                spi_sck_func,
  input logic [N_CHAINS-2:0] gp_pad_in,
  input logic [N_CHAINS-2:0] gp_func_in,
  input logic [N_CHAINS-2:0] gp_func_out,
  input logic [N_CHAINS-2:0] gp_pad_out,
  input logic                scan_mode,
  input logic                scan_shift_en,
  input logic                scan_clk,
  input logic [N_CHAINS-1:0] scan_si,
  input logic [N_CHAINS-1:0] scan_so,
  input logic                scan_instr_flag
);

  a_r7_idle_controls: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_mode |-> (!scan_shift_en && !scan_clk && scan_si == '0));

  a_r6_hold_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_pin |=> $stable(scan_mode));

  a_r11_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_mode |-> (uart_tx_pad == uart_tx_func && uart_rx_func == uart_rx_pad &&
                    spi_sck_func == spi_sck_pad && gp_pad_out == gp_func_out &&
                    gp_func_in == gp_pad_in));

  a_r8_jtag_route: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && scan_cfg == 2'd1) |-> (tdo == scan_so[0] && scan_si[0] == tdi && scan_clk == tck));

  a_r9_uart_route: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && scan_cfg == 2'd2) |-> (uart_tx_pad == scan_so[0] && scan_si[0] == uart_rx_pad &&
                                          scan_clk == spi_sck_pad && uart_rx_func && !spi_sck_func));

  a_r10_gp_route: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |-> (gp_pad_out == scan_so[N_CHAINS-1:1] && scan_si[N_CHAINS-1:1] == gp_pad_in &&
                   gp_func_in == '0));

  a_r5_trst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n |-> !scan_instr_flag);

endmodule

bind scan_pin_router scan_pin_router_chk #(.N_CHAINS(N_CHAINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_cfg(scan_cfg), .scan_en_pin(scan_en_pin),
  .tck(tck), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
  .uart_rx_pad(uart_rx_pad), .uart_rx_func(uart_rx_func),
  .uart_tx_func(uart_tx_func), .uart_tx_pad(uart_tx_pad),
  .spi_sck_pad(spi_sck_pad), .spi_sck_func(spi_sck_func),
  .gp_pad_in(gp_pad_in), .gp_func_in(gp_func_in),
  .gp_func_out(gp_func_out), .gp_pad_out(gp_pad_out),
  .scan_mode(scan_mode), .scan_shift_en(scan_shift_en), .scan_clk(scan_clk),
  .scan_si(scan_si), .scan_so(scan_so), .scan_instr_flag(scan_instr_flag)
);

// File: tb/scan_pin_router_tb_top.sv
`timescale 1ns/1ps
module scan_pin_router_tb_top;

  localparam int NC = 3;
  localparam int GW = NC - 1;
  localparam int IRW = 4;
  localparam logic [IRW-1:0] OP_SCAN = 4'b1000;
  localparam logic [IRW-1:0] OP_BYP  = 4'b1111;

  logic clk = 0, rst_n = 0, trst_n = 0;
  logic [1:0] scan_cfg = 0;
  logic scan_mode_pin = 0, scan_en_pin = 0;
  logic tck = 0, tms = 0, tdi = 0, tdo;
  logic uart_rx_pad = 1, uart_rx_func, uart_tx_func = 0, uart_tx_pad;
  logic spi_sck_pad = 0, spi_sck_func;
  logic [GW-1:0] gp_pad_in = 0, gp_func_in, gp_func_out = 0, gp_pad_out;
  logic scan_mode, scan_shift_en, scan_clk;
  logic [NC-1:0] scan_si, scan_so;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  scan_pin_router #(.N_CHAINS(NC), .IR_W(IRW), .SCAN_OP(OP_SCAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_cfg(scan_cfg), .scan_mode_pin(scan_mode_pin),
    .scan_en_pin(scan_en_pin), .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
    .tdo(tdo), .uart_rx_pad(uart_rx_pad), .uart_rx_func(uart_rx_func),
    .uart_tx_func(uart_tx_func), .uart_tx_pad(uart_tx_pad),
    .spi_sck_pad(spi_sck_pad), .spi_sck_func(spi_sck_func),
    .gp_pad_in(gp_pad_in), .gp_func_in(gp_func_in), .gp_func_out(gp_func_out),
    .gp_pad_out(gp_pad_out), .scan_mode(scan_mode), .scan_shift_en(scan_shift_en),
    .scan_clk(scan_clk), .scan_si(scan_si), .scan_so(scan_so));

  // chains living outside the block
  function automatic int clen(int i);
    return 5 + i;
  endfunction

  logic [15:0] ch [NC];
  initial for (int i = 0; i < NC; i++) ch[i] = '0;
  always @(posedge scan_clk)
    if (scan_shift_en)
      for (int i = 0; i < NC; i++) ch[i] <= {ch[i][14:0], scan_si[i]};
  always_comb
    for (int i = 0; i < NC; i++) scan_so[i] = ch[i][clen(i)-1];

  // core-side functional traffic
  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    uart_tx_func <= cyc[0] ^ cyc[3];
    gp_func_out  <= GW'(cyc >> 2);
  end

  // behavioural model
  logic m_flag = 0, m_mode = 0;
  logic rq [3];
  logic sh [3];
  initial for (int i = 0; i < 3; i++) begin rq[i] = 0; sh[i] = 0; end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_mode = 0;
      for (int i = 0; i < 3; i++) begin rq[i] = 0; sh[i] = 0; end
    end else begin
      if (!(scan_en_pin || sh[0] || sh[1])) m_mode = rq[1];
      rq[1] = rq[0];
      rq[0] = (scan_mode_pin | m_flag) & (scan_cfg == 2'd1 || scan_cfg == 2'd2);
      sh[1] = sh[0];
      sh[0] = scan_en_pin;
    end
    #1;
    begin
      logic jt, ua, e_clk, e_si0;
      logic [NC-1:0] e_si;
      jt = m_mode && scan_cfg == 2'd1;
      ua = m_mode && scan_cfg == 2'd2;
      e_clk = jt ? tck : (ua ? spi_sck_pad : 1'b0);
      e_si0 = jt ? tdi : (ua ? uart_rx_pad : 1'b0);
      e_si = m_mode ? {gp_pad_in, e_si0} : {{GW{1'b0}}, e_si0};
      checks++;
      if (scan_mode !== m_mode) begin fails++;
        $display("FAIL R3/R6 scan_mode actual=%0b expected=%0b at %0t", scan_mode, m_mode, $time); end
      if (scan_shift_en !== (m_mode & scan_en_pin)) begin fails++;
        $display("FAIL R7 shift_en actual=%0b expected=%0b", scan_shift_en, m_mode & scan_en_pin); end
      if (scan_clk !== e_clk) begin fails++;
        $display("FAIL R7 scan_clk actual=%0b expected=%0b", scan_clk, e_clk); end
      if (scan_si !== e_si) begin fails++;
        $display("FAIL R10 scan_si actual=%0b expected=%0b", scan_si, e_si); end
      if (uart_tx_pad !== (ua ? scan_so[0] : uart_tx_func)) begin fails++;
        $display("FAIL R9 uart_tx_pad actual=%0b expected=%0b", uart_tx_pad, ua ? scan_so[0] : uart_tx_func); end
      if (uart_rx_func !== (ua ? 1'b1 : uart_rx_pad)) begin fails++;
        $display("FAIL R11 uart_rx_func actual=%0b expected=%0b", uart_rx_func, ua ? 1'b1 : uart_rx_pad); end
      if (spi_sck_func !== (ua ? 1'b0 : spi_sck_pad)) begin fails++;
        $display("FAIL R11 spi_sck_func actual=%0b expected=%0b", spi_sck_func, ua ? 1'b0 : spi_sck_pad); end
      if (gp_pad_out !== (m_mode ? scan_so[NC-1:1] : gp_func_out)) begin fails++;
        $display("FAIL R10 gp_pad_out actual=%0b expected=%0b", gp_pad_out, m_mode ? scan_so[NC-1:1] : gp_func_out); end
      if (gp_func_in !== (m_mode ? '0 : gp_pad_in)) begin fails++;
        $display("FAIL R10 gp_func_in actual=%0b expected=%0b", gp_func_in, m_mode ? '0 : gp_pad_in); end
      if (jt && tdo !== scan_so[0]) begin fails++;
        $display("FAIL R8 tdo actual=%0b expected=%0b", tdo, scan_so[0]); end
    end
  end

  // stimulus helpers
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tck_cycle(input logic tms_v, input logic tdi_v, input int fx, output logic tdo_v);
    @(negedge clk);
    tms = tms_v; tdi = tdi_v; tdo_v = tdo;
    @(negedge clk);
    tck = 1;
    if (fx >= 0) m_flag = fx[0];
    @(negedge clk);
    tck = 0;
  endtask

  task automatic load_ir(input logic [IRW-1:0] op, input bit cap_chk);
    logic t;
    tck_cycle(0, 0, -1, t);
    tck_cycle(1, 0, -1, t);
    tck_cycle(1, 0, -1, t);
    tck_cycle(0, 0, -1, t);
    tck_cycle(0, 0, -1, t);
    for (int b = 0; b < IRW; b++) begin
      tck_cycle(b == IRW-1, op[b], -1, t);
      if (cap_chk) chk(t === (b == 0), "R11 IR capture bit on tdo", t, b == 0);
    end
    tck_cycle(1, 0, -1, t);
    tck_cycle(0, 0, (op == OP_SCAN) ? 1 : 0, t);
  endtask

  task automatic go_tlr();
    logic t;
    tck_cycle(1, 0, -1, t);
    tck_cycle(1, 0, -1, t);
    for (int i = 0; i < 3; i++) tck_cycle(1, 0, 0, t);
    tck_cycle(0, 0, -1, t);
  endtask

  function automatic logic pat(int i, int k);
    return 1'((((k * 13) + (i * 5)) >> 2) & 1);
  endfunction

  task automatic shift_chains(input int nbits, input bit on_jtag);
    logic sent [NC][32];
    logic got;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      for (int i = 0; i < NC; i++) sent[i][k] = pat(i, k);
      if (on_jtag) tdi = sent[0][k]; else uart_rx_pad = sent[0][k];
      for (int i = 1; i < NC; i++) gp_pad_in[i-1] = sent[i][k];
      @(negedge clk);
      if (on_jtag) tck = 1; else spi_sck_pad = 1;
      @(negedge clk);
      for (int i = 0; i < NC; i++)
        if (k >= clen(i) - 1) begin
          got = (i == 0) ? (on_jtag ? tdo : uart_tx_pad) : gp_pad_out[i-1];
          if (i == 0 && on_jtag)
            chk(got === sent[i][k-clen(i)+1], "R8 chain0 bit on tdo", got, sent[i][k-clen(i)+1]);
          else if (i == 0)
            chk(got === sent[i][k-clen(i)+1], "R9 chain0 bit on uart_tx_pad", got, sent[i][k-clen(i)+1]);
          else
            chk(got === sent[i][k-clen(i)+1], "R10 gp chain bit", got, sent[i][k-clen(i)+1]);
        end
      if (on_jtag) tck = 0; else spi_sck_pad = 0;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    edges(4);
    chk(scan_mode === 0 && scan_shift_en === 0 && scan_clk === 0 && scan_si === '0,
        "R1 reset outputs", {scan_mode, scan_shift_en, scan_clk}, 0);
    chk(uart_tx_pad === uart_tx_func, "R1 uart_tx pass in reset", uart_tx_pad, uart_tx_func);
    @(negedge clk); rst_n = 1; trst_n = 1;

    // R11 functional traffic with pads toggling
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      uart_rx_pad = 1'(n >> 1); spi_sck_pad = 1'(n >> 2); gp_pad_in = GW'(n * 3);
    end
    uart_rx_pad = 1; spi_sck_pad = 0; gp_pad_in = 0;
    load_ir(OP_BYP, 1);

    // R2 configuration 0 blocks both request sources
    @(negedge clk); scan_mode_pin = 1;
    load_ir(OP_SCAN, 0);
    edges(8);
    chk(scan_mode === 0, "R2 cfg0 keeps scan_mode low", scan_mode, 0);
    load_ir(OP_BYP, 0);
    @(negedge clk); scan_mode_pin = 0;
    edges(4);

    // R3 pin entry, JTAG scheme
    @(negedge clk); scan_cfg = 1;
    edges(4);
    @(negedge clk); scan_mode_pin = 1;
    edges(2);
    chk(scan_mode === 0, "R3 not yet after two edges", scan_mode, 0);
    edges(1);
    chk(scan_mode === 1, "R3 on third edge", scan_mode, 1);
    @(negedge clk); scan_en_pin = 1;
    shift_chains(14, 1);

    // R6 mode held while shifting
    @(negedge clk); scan_mode_pin = 0;
    edges(6);
    chk(scan_mode === 1, "R6 held while shift enable high", scan_mode, 1);
    @(negedge clk); scan_en_pin = 0;
    edges(2);
    chk(scan_mode === 1, "R6 still held two edges after release", scan_mode, 1);
    edges(1);
    chk(scan_mode === 0, "R6 drops on third edge", scan_mode, 0);
    @(negedge clk); scan_en_pin = 1; scan_mode_pin = 1;
    edges(6);
    chk(scan_mode === 0, "R6 entry blocked by shift enable", scan_mode, 0);
    @(negedge clk); scan_en_pin = 0;
    edges(3);
    chk(scan_mode === 1, "R6 entry after release", scan_mode, 1);
    @(negedge clk); scan_mode_pin = 0;
    edges(4);
    chk(scan_mode === 0, "R3 exit", scan_mode, 0);

    // R4 instruction entry, UART/SPI scheme
    @(negedge clk); scan_cfg = 2;
    load_ir(OP_SCAN, 1);
    edges(4);
    chk(scan_mode === 1, "R4 instruction enters scan", scan_mode, 1);
    chk(uart_rx_func === 1 && spi_sck_func === 0, "R9 functional side parked", {uart_rx_func, spi_sck_func}, 2);
    @(negedge clk); scan_en_pin = 1;
    shift_chains(16, 0);
    @(negedge clk); scan_en_pin = 0;
    edges(4);

    // R5 clearing paths
    load_ir(OP_BYP, 0);
    edges(4);
    chk(scan_mode === 0, "R5 other opcode clears", scan_mode, 0);
    load_ir(OP_SCAN, 0);
    edges(4);
    chk(scan_mode === 1, "R4 re-entry", scan_mode, 1);
    go_tlr();
    edges(4);
    chk(scan_mode === 0, "R5 Test-Logic-Reset clears", scan_mode, 0);
    load_ir(OP_SCAN, 0);
    edges(4);
    chk(scan_mode === 1, "R4 re-entry before trst", scan_mode, 1);
    @(negedge clk); trst_n = 0; m_flag = 0;
    @(negedge clk); trst_n = 1;
    edges(4);
    chk(scan_mode === 0, "R5 trst_n clears", scan_mode, 0);
    chk(uart_tx_pad === uart_tx_func, "R11 uart_tx back to function", uart_tx_pad, uart_tx_func);

    edges(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule